// File: doc/BRIEF.md
# Character Cell Text Renderer

This block turns raster coordinates from an external 1440 × 900 timing generator into a 6-bit RRGGBB text display. The screen is split into cells 8 pixels wide and 16 lines tall, which gives 180 columns by 56 rows. Each cell has a 16-bit entry in the character memory. The entry holds an 8-bit glyph code, a 4-bit foreground colour index and a 4-bit background colour index. The glyph memory holds one byte per glyph line for each of 256 glyphs.

The renderer works in three steps. It reads the cell entry, then reads the glyph line that the entry and the current line within the cell point to, and then picks one bit of that line. A set bit shows the foreground colour and a clear bit shows the background colour. Both colour indices pass through a fixed 16-entry palette. The sync signals follow the same two-cycle path so that the colour and the syncs leave the block together.

A host loads both memories through two simple write ports. The 900-line screen holds only 56 full rows of cells, so lines 896 to 899 are shown black.

Top module: `text_cell_renderer`

## Requirements
- R1: Pixel (x, y) with y < 896 uses the character entry at address (y / 16) × 180 + (x / 8). Bits 7:0 of that entry are the glyph code.
- R2: The glyph line is read at address code × 16 + (y mod 16). Bit 7 of the byte is the leftmost pixel of the cell, so pixel x uses bit 7 − (x mod 8).
- R3: A set glyph bit outputs the palette colour of entry bits 11:8 (foreground). A clear bit outputs the palette colour of entry bits 15:12 (background).
- R4: The palette maps index i to RRGGBB = {i[2], i[3], i[1], i[3], i[0], i[3]}. Index 0 is 6'h00, index 15 is 6'h3F, index 4 is 6'h20, index 9 is 6'h17, index 10 is 6'h1D, index 2 is 6'h08 and index 5 is 6'h22.
- R5: The colour output and both sync outputs appear exactly two clock cycles after the coordinates, active flag and syncs are presented.
- R6: The colour output is 6'h00 whenever the active flag was low two cycles earlier.
- R7: Lines 896 to 899 output 6'h00 even while the active flag is high.
- R8: While reset is high, the colour output and both sync outputs are driven to zero on the next clock edge.
- R9: A write to either memory changes what the following reads return, so a rewritten cell entry changes the colours shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_x | input | 11 | Horizontal raster position |
| pix_y | input | 10 | Vertical raster position |
| pix_active | input | 1 | High during visible pixels |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| cell_we | input | 1 | Write strobe for the character memory |
| cell_waddr | input | 14 | Character memory write address |
| cell_wdata | input | 16 | Entry to write: {bg[3:0], fg[3:0], code[7:0]} |
| font_we | input | 1 | Write strobe for the glyph memory |
| font_waddr | input | 12 | Glyph memory write address (code × 16 + line) |
| font_wdata | input | 8 | Glyph line bitmap, bit 7 is the leftmost pixel |
| rgb_out | output | 6 | Pixel colour as RRGGBB |
| hsync_out | output | 1 | Horizontal sync, delayed by two cycles |
| vsync_out | output | 1 | Vertical sync, delayed by two cycles |

## Verification
Each colour value and each sync level is due on the second rising edge after its inputs are applied. The memory writes take effect from the cycle after the write strobe. The bench drives inputs on the falling edge, holds them across two rising edges and samples 1 ns after the second one. One directed test samples after the first rising edge and confirms that the previous colour is still shown there. The checker uses a reset-age counter, so its two-cycle look-back never reaches into the cycles before reset was released.

// File: rtl/txr_pkg.sv
package txr_pkg;
  parameter int COLS       = 180;
  parameter int ROWS       = 56;
  parameter int GLYPH_W    = 8;
  parameter int GLYPH_H    = 16;
  parameter int GLYPHS     = 256;
  parameter int IDX_W      = 4;
  parameter int RGB_W      = 6;
  parameter int X_W        = 11;
  parameter int Y_W        = 10;

  localparam int CELLS      = COLS * ROWS;
  localparam int CELL_AW    = $clog2(CELLS);
  localparam int CODE_W     = $clog2(GLYPHS);
  localparam int ENTRY_W    = CODE_W + 2 * IDX_W;
  localparam int LINE_W     = $clog2(GLYPH_H);
  localparam int PX_W       = $clog2(GLYPH_W);
  localparam int FONT_DEPTH = GLYPHS * GLYPH_H;
  localparam int FONT_AW    = $clog2(FONT_DEPTH);
  localparam int TEXT_LINES = ROWS * GLYPH_H;
  localparam int TEXT_PIX   = COLS * GLYPH_W;

  // Linear cell index from a row and a column.
  function automatic logic [CELL_AW-1:0] cell_index(input logic [Y_W-1:0] row,
                                                    input logic [X_W-1:0] col);
    logic [CELL_AW-1:0] r;
    logic [CELL_AW-1:0] c;
    r = CELL_AW'(row);
    c = CELL_AW'(col);
    return r * CELL_AW'(COLS) + c;
  endfunction

  // Fixed palette: each channel is {colour bit, intensity bit}.
  function automatic logic [RGB_W-1:0] pal_rgb(input logic [IDX_W-1:0] idx);
    return {idx[2], idx[3], idx[1], idx[3], idx[0], idx[3]};
  endfunction
endpackage

// File: rtl/txr_sync_ram.sv
module txr_sync_ram #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  logic wr_ok;
  logic rd_ok;
  assign wr_ok = ({1'b0, waddr} < (AW+1)'(DEPTH));
  assign rd_ok = ({1'b0, raddr} < (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (we && wr_ok) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= rd_ok ? mem[raddr] : '0;
  end
endmodule

// File: rtl/txr_addr_stage.sv
module txr_addr_stage
  import txr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [X_W-1:0]     pix_x,
  input  logic [Y_W-1:0]     pix_y,
  input  logic               pix_active,
  input  logic               hsync_in,
  input  logic               vsync_in,
  output logic [CELL_AW-1:0] rd_addr,
  output logic [LINE_W-1:0]  line_q,
  output logic [PX_W-1:0]    px_q,
  output logic               vis_q,
  output logic               hs_q,
  output logic               vs_q
);
  logic in_text;
  logic [Y_W-1:0] row;
  logic [X_W-1:0] col;

  assign in_text = (pix_y < Y_W'(TEXT_LINES)) && (pix_x < X_W'(TEXT_PIX));
  assign row     = pix_y >> LINE_W;
  assign col     = pix_x >> PX_W;
  assign rd_addr = in_text ? cell_index(row, col) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      px_q   <= '0;
      vis_q  <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
    end else begin
      line_q <= pix_y[LINE_W-1:0];
      px_q   <= pix_x[PX_W-1:0];
      vis_q  <= pix_active && in_text;
      hs_q   <= hsync_in;
      vs_q   <= vsync_in;
    end
  end
endmodule

// File: rtl/txr_pixel_stage.sv
module txr_pixel_stage
  import txr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LINE_W-1:0]  line_q1,
  input  logic [PX_W-1:0]    px_q1,
  input  logic               vis_q1,
  input  logic               hs_q1,
  input  logic               vs_q1,
  input  logic [GLYPH_W-1:0] glyph_row,
  output logic [FONT_AW-1:0] font_raddr,
  output logic [RGB_W-1:0]   fg_rgb,
  output logic [RGB_W-1:0]   bg_rgb,
  output logic               vis_q2,
  output logic [RGB_W-1:0]   rgb_out,
  output logic               hsync_out,
  output logic               vsync_out
);
  localparam logic [PX_W-1:0] LEFT_BIT = PX_W'(GLYPH_W - 1);

  logic [IDX_W-1:0] fg_q2;
  logic [IDX_W-1:0] bg_q2;
  logic [PX_W-1:0]  px_q2;
  logic             pix_on;

  assign font_raddr = {entry[CODE_W-1:0], line_q1};

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q2     <= '0;
      bg_q2     <= '0;
      px_q2     <= '0;
      vis_q2    <= 1'b0;
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
    end else begin
      fg_q2     <= entry[CODE_W +: IDX_W];
      bg_q2     <= entry[CODE_W+IDX_W +: IDX_W];
      px_q2     <= px_q1;
      vis_q2    <= vis_q1;
      hsync_out <= hs_q1;
      vsync_out <= vs_q1;
    end
  end

  assign pix_on  = glyph_row[LEFT_BIT - px_q2];
  assign fg_rgb  = pal_rgb(fg_q2);
  assign bg_rgb  = pal_rgb(bg_q2);
  assign rgb_out = vis_q2 ? (pix_on ? fg_rgb : bg_rgb) : '0;
endmodule

// File: rtl/text_cell_renderer.sv
module text_cell_renderer
  import txr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [X_W-1:0]     pix_x,
  input  logic [Y_W-1:0]     pix_y,
  input  logic               pix_active,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               cell_we,
  input  logic [CELL_AW-1:0] cell_waddr,
  input  logic [ENTRY_W-1:0] cell_wdata,
  input  logic               font_we,
  input  logic [FONT_AW-1:0] font_waddr,
  input  logic [GLYPH_W-1:0] font_wdata,
  output logic [RGB_W-1:0]   rgb_out,
  output logic               hsync_out,
  output logic               vsync_out
);
  logic [CELL_AW-1:0] rd_addr;
  logic [LINE_W-1:0]  line_q1;
  logic [PX_W-1:0]    px_q1;
  logic               vis_q1;
  logic               hs_q1;
  logic               vs_q1;
  logic [ENTRY_W-1:0] entry;
  logic [FONT_AW-1:0] font_raddr;
  logic [GLYPH_W-1:0] glyph_row;
  logic [RGB_W-1:0]   fg_rgb;
  logic [RGB_W-1:0]   bg_rgb;
  logic               vis_q2;

  txr_addr_stage u_addr (
    .clk(clk), .rst(rst),
    .pix_x(pix_x), .pix_y(pix_y), .pix_active(pix_active),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .rd_addr(rd_addr), .line_q(line_q1), .px_q(px_q1),
    .vis_q(vis_q1), .hs_q(hs_q1), .vs_q(vs_q1)
  );

  txr_sync_ram #(.DEPTH(CELLS), .WIDTH(ENTRY_W)) u_cells (
    .clk(clk), .we(cell_we), .waddr(cell_waddr), .wdata(cell_wdata),
    .raddr(rd_addr), .rdata(entry)
  );

  txr_sync_ram #(.DEPTH(FONT_DEPTH), .WIDTH(GLYPH_W)) u_font (
    .clk(clk), .we(font_we), .waddr(font_waddr), .wdata(font_wdata),
    .raddr(font_raddr), .rdata(glyph_row)
  );

  txr_pixel_stage u_pix (
    .clk(clk), .rst(rst),
    .entry(entry), .line_q1(line_q1), .px_q1(px_q1),
    .vis_q1(vis_q1), .hs_q1(hs_q1), .vs_q1(vs_q1),
    .glyph_row(glyph_row), .font_raddr(font_raddr),
    .fg_rgb(fg_rgb), .bg_rgb(bg_rgb), .vis_q2(vis_q2),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );
endmodule

// File: rtl/text_cell_renderer_chk.sv
module text_cell_renderer_chk
  import txr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [Y_W-1:0]     pix_y,
  input logic               pix_active,
  input logic               hsync_in,
  input logic               vsync_in,
  input logic [RGB_W-1:0]   rgb_out,
  input logic               hsync_out,
  input logic               vsync_out,
  input logic [RGB_W-1:0]   fg_rgb,
  input logic [RGB_W-1:0]   bg_rgb,
  input logic               vis_q2,
  input logic [CELL_AW-1:0] rd_addr
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R5
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (hsync_out == $past(hsync_in, 2) && vsync_out == $past(vsync_in, 2)));

  // R6
  blank_inactive_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !$past(pix_active, 2)) |-> (rgb_out == '0));

  // R7
  bottom_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(pix_y, 2) >= Y_W'(TEXT_LINES)) |-> (rgb_out == '0));

  // R3
  colour_choice_chk: assert property (@(posedge clk) disable iff (rst)
    vis_q2 |-> (rgb_out == fg_rgb || rgb_out == bg_rgb));

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rd_addr} < (CELL_AW+1)'(CELLS)));

  // R8
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (rgb_out == '0 && !hsync_out && !vsync_out));
endmodule

bind text_cell_renderer text_cell_renderer_chk u_chk (
  .clk(clk), .rst(rst), .pix_y(pix_y), .pix_active(pix_active),
  .hsync_in(hsync_in), .vsync_in(vsync_in),
  .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
  .fg_rgb(fg_rgb), .bg_rgb(bg_rgb), .vis_q2(vis_q2), .rd_addr(rd_addr)
);

// File: tb/text_cell_renderer_bench.sv
`timescale 1ns/1ps
module text_cell_renderer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] pix_x = '0;
  logic [9:0]  pix_y = '0;
  logic        pix_active = 1'b0;
  logic        hsync_in = 1'b0;
  logic        vsync_in = 1'b0;
  logic        cell_we = 1'b0;
  logic [13:0] cell_waddr = '0;
  logic [15:0] cell_wdata = '0;
  logic        font_we = 1'b0;
  logic [11:0] font_waddr = '0;
  logic [7:0]  font_wdata = '0;
  logic [5:0]  rgb_out;
  logic        hsync_out;
  logic        vsync_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  text_cell_renderer u_text_cell_renderer (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .pix_active(pix_active),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .cell_we(cell_we), .cell_waddr(cell_waddr), .cell_wdata(cell_wdata),
    .font_we(font_we), .font_waddr(font_waddr), .font_wdata(font_wdata),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  // {x, y, active, hsync, vsync, expected rgb}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {11'd0,    10'd0,   1'b1, 1'b0, 1'b0, 6'h3F}, // R1 R2 R3 leftmost bit set, fg 15
    {11'd1,    10'd0,   1'b1, 1'b1, 1'b0, 6'h00}, // R2 R3 clear bit, bg 0
    {11'd7,    10'd0,   1'b1, 1'b0, 1'b1, 6'h3F}, // R2 rightmost bit
    {11'd5,    10'd5,   1'b1, 1'b1, 1'b1, 6'h3F}, // R2 line 5 = 0x0F, bit 2
    {11'd3,    10'd5,   1'b1, 1'b0, 1'b0, 6'h00}, // R2 line 5 bit 4 clear
    {11'd16,   10'd16,  1'b1, 1'b0, 1'b0, 6'h1D}, // R1 R4 row 1 col 2, fg 10
    {11'd17,   10'd16,  1'b1, 1'b0, 1'b0, 6'h08}, // R4 bg 2
    {11'd1439, 10'd895, 1'b1, 1'b0, 1'b0, 6'h20}, // R1 R4 last cell, fg 4
    {11'd1432, 10'd895, 1'b1, 1'b0, 1'b0, 6'h17}, // R4 bg 9
    {11'd0,    10'd0,   1'b0, 1'b1, 1'b0, 6'h00}, // R6 inactive
    {11'd1439, 10'd896, 1'b1, 1'b0, 1'b1, 6'h00}, // R7 first unused line
    {11'd0,    10'd899, 1'b1, 1'b0, 1'b0, 6'h00}  // R7 last line
  };

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put_cell(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk); cell_we = 1'b1; cell_waddr = a; cell_wdata = d;
    @(negedge clk); cell_we = 1'b0;
  endtask

  task automatic put_font(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); font_we = 1'b1; font_waddr = a; font_wdata = d;
    @(negedge clk); font_we = 1'b0;
  endtask

  task automatic drive(input logic [10:0] x, input logic [9:0] y, input logic a,
                       input logic h, input logic v);
    @(negedge clk);
    pix_x = x; pix_y = y; pix_active = a; hsync_in = h; vsync_in = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    hsync_in = 1'b1; vsync_in = 1'b1; pix_active = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 rgb", rgb_out, 6'h00);
    check("R8 syncs", {4'b0, hsync_out, vsync_out}, 6'h00);
    @(negedge clk);
    hsync_in = 1'b0; vsync_in = 1'b0; pix_active = 1'b0;
    rst = 1'b0;

    put_cell(14'd0,     16'h0F41);
    put_cell(14'd182,   16'h2A41);
    put_cell(14'd10079, 16'h9402);
    put_font(12'h410, 8'hA1);   // glyph 0x41 line 0
    put_font(12'h415, 8'h0F);   // glyph 0x41 line 5
    put_font(12'h02F, 8'h01);   // glyph 0x02 line 15

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:19], VEC[i][18:9], VEC[i][8], VEC[i][7], VEC[i][6]);
      @(posedge clk); @(posedge clk); #1;
      check($sformatf("R2/R3/R6/R7 vector %0d rgb", i), rgb_out, VEC[i][5:0]);
      check($sformatf("R5 vector %0d syncs", i), {4'b0, hsync_out, vsync_out},
            {4'b0, VEC[i][7], VEC[i][6]});
    end

    // R5: one edge after a change the old colour is still shown
    drive(11'd1, 10'd0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); @(posedge clk); #1;
    check("R5 setup", rgb_out, 6'h00);
    drive(11'd0, 10'd0, 1'b1, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R5 after one edge", rgb_out, 6'h00);
    check("R5 sync after one edge", {5'b0, hsync_out}, 6'h00);
    @(posedge clk); #1;
    check("R5 after two edges", rgb_out, 6'h3F);
    check("R5 sync after two edges", {5'b0, hsync_out}, 6'h01);

    // R9: rewrite cell 0 with bg 5
    put_cell(14'd0, 16'h5F41);
    drive(11'd1, 10'd0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); @(posedge clk); #1;
    check("R9 new bg", rgb_out, 6'h22);
    // R9: rewrite glyph 0x41 line 0 so pixel 1 is set
    put_font(12'h410, 8'h40);
    drive(11'd1, 10'd0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); @(posedge clk); #1;
    check("R9 new glyph", rgb_out, 6'h3F);

    // R8: reset mid-run clears outputs
    drive(11'd0, 10'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R8 mid-run rgb", rgb_out, 6'h00);
    check("R8 mid-run syncs", {4'b0, hsync_out, vsync_out}, 6'h00);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);

    finish_run();
  end
endmodule